// File: doc/BRIEF.md
# Wiper Tap Position Counter

This block keeps the tap position of one resistor array as a 6-bit count and turns it into a 64-bit switch-enable vector in which exactly one tap is on. Code 0 selects the low end of the array and code 63 selects the high end. Three sources can replace the count completely: a direct serial write, a transfer from a stored data register, and the recall value presented during reset. The reset recall models the power-up load from data register 0 of the same channel. The count is volatile.

While the command decoder holds the stepping mode open, each serial-clock pulse event moves the count by one tap. The serial-data level at that pulse picks the direction: high steps toward the high end and low steps toward the low end. The mode stays open for any number of pulses until chip select returns high, and the decoder then clears the mode flag. The decoder only opens the mode for the two wiper counters, never for a control register. The count stops at either end and never wraps. The one-hot vector is registered from the count one clock later, so it cannot glitch through intermediate codes.

Top module: `wiper_pos_counter`

## Requirements
- R1: While `rst_n` is low at a clock edge, `tap_pos` takes `recall_val` and `tap_sel` takes the one-hot code of `recall_val`.
- R2: A clock edge with `load_en` high replaces `tap_pos` with `load_val`, whatever the previous count was.
- R3: `tap_sel` always has exactly one bit set, and bit k is set one clock after `tap_pos` equals k. Code 0 sets bit 0 (low end) and code 63 sets bit 63 (high end).
- R4: With `step_mode` high, a clock edge with `step_pulse` high and `step_up` high raises `tap_pos` by one.
- R5: With `step_mode` high, a clock edge with `step_pulse` high and `step_up` low lowers `tap_pos` by one.
- R6: An upward step at count 63 leaves the count at 63.
- R7: A downward step at count 0 leaves the count at 0.
- R8: `step_pulse` has no effect while `step_mode` is low. `step_up` changes nothing in any cycle without a pulse.
- R9: When `load_en` and a step arrive at the same edge, the load wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the recall value |
| recall_val | input | 6 | Value restored at reset (data register 0 of this channel) |
| load_en | input | 1 | Parallel load strobe (serial write or register transfer) |
| load_val | input | 6 | Value taken on a parallel load |
| step_mode | input | 1 | Increment/decrement command open |
| step_pulse | input | 1 | One-cycle event for each serial-clock pulse |
| step_up | input | 1 | Serial-data level at the pulse; 1 = toward high end |
| tap_pos | output | 6 | Current tap position |
| tap_sel | output | 64 | One-hot tap switch enables |

## Verification
A load or a step registers into `tap_pos` at the first clock edge that sees it. `tap_sel` follows one edge later. At reset both take the recall value at the same edge. The bench drives inputs on falling edges and reads `tap_pos` at the next falling edge. It reads `tap_sel` one full cycle after that, so each result is sampled in the cycle it is due. The stepping, end-stop and ignore cases also check that the count does not move in the cycles where it must not.

// File: rtl/wiper_pkg.sv
// Shared definitions for the wiper position counter.
// Assumes: position widths are set by the top-level parameter.
package wiper_pkg;
    // Action picked for the counter in a given cycle
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_INC  = 2'd2,
        ACT_DEC  = 2'd3
    } wiper_act_e;
endpackage

// File: rtl/wiper_step_ctrl.sv
// Next-count logic: chooses load, step up, step down or hold, and
// saturates at both ends of the range.
// Assumes: step_pulse is a single-cycle event per serial-clock pulse.
module wiper_step_ctrl
    import wiper_pkg::*;
#(
    parameter int POS_W = 6
) (
    input  logic [POS_W-1:0] cur_pos,
    input  logic             load_en,
    input  logic [POS_W-1:0] load_val,
    input  logic             step_mode,
    input  logic             step_pulse,
    input  logic             step_up,
    output logic [POS_W-1:0] nxt_pos,
    output wiper_act_e       act
);
    localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};
    localparam logic [POS_W-1:0] POS_MIN = '0;

    // Pick the action; a load has priority over a step
    always_comb begin
        if (load_en)
            act = ACT_LOAD;
        else if (step_mode && step_pulse)
            act = step_up ? ACT_INC : ACT_DEC;
        else
            act = ACT_HOLD;
    end

    // Compute the next count, holding at the ends
    always_comb begin
        unique case (act)
            ACT_LOAD: nxt_pos = load_val;
            ACT_INC:  nxt_pos = (cur_pos == POS_MAX) ? cur_pos : cur_pos + 1'b1;
            ACT_DEC:  nxt_pos = (cur_pos == POS_MIN) ? cur_pos : cur_pos - 1'b1;
            default:  nxt_pos = cur_pos;
        endcase
    end
endmodule

// File: rtl/wiper_tap_decode.sv
// Registered position-to-one-hot decoder: one enable per tap.
// Assumes: reset loads the same value as the counter so both agree.
module wiper_tap_decode #(
    parameter int POS_W = 6,
    parameter int TAPS  = 1 << POS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [POS_W-1:0] recall_val,
    input  logic [POS_W-1:0] pos_in,
    output logic [TAPS-1:0]  sel_out
);
    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        // Register the enable of tap k from the compare
        always_ff @(posedge clk) begin
            if (!rst_n)
                sel_out[k] <= (recall_val == POS_W'(k));
            else
                sel_out[k] <= (pos_in == POS_W'(k));
        end
    end
endmodule

// File: rtl/wiper_pos_counter.sv
// Tap position counter for one resistor array. Loads in parallel,
// steps by one per serial-clock pulse in stepping mode, saturates at
// both ends, and drives a registered one-hot tap-enable vector.
// Assumes: the command decoder clears step_mode when chip select rises
// and only opens it for the wiper counters.
module wiper_pos_counter
    import wiper_pkg::*;
#(
    parameter int POS_W = 6,
    localparam int TAPS = 1 << POS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [POS_W-1:0] recall_val,
    input  logic             load_en,
    input  logic [POS_W-1:0] load_val,
    input  logic             step_mode,
    input  logic             step_pulse,
    input  logic             step_up,
    output logic [POS_W-1:0] tap_pos,
    output logic [TAPS-1:0]  tap_sel
);
    localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};
    localparam logic [TAPS-1:0]  SEL_ONE = {{(TAPS-1){1'b0}}, 1'b1};

    logic [POS_W-1:0] nxt_pos;
    wiper_act_e       act;

    wiper_step_ctrl #(.POS_W(POS_W)) u_ctrl (
        .cur_pos   (tap_pos),
        .load_en   (load_en),
        .load_val  (load_val),
        .step_mode (step_mode),
        .step_pulse(step_pulse),
        .step_up   (step_up),
        .nxt_pos   (nxt_pos),
        .act       (act)
    );

    // Hold the count; reset recalls the stored value
    always_ff @(posedge clk) begin
        if (!rst_n)
            tap_pos <= recall_val;
        else
            tap_pos <= nxt_pos;
    end

    wiper_tap_decode #(.POS_W(POS_W), .TAPS(TAPS)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .recall_val(recall_val),
        .pos_in    (tap_pos),
        .sel_out   (tap_sel)
    );

    // R1: reset edge captures the recall value
    assert_recall_R1: assert property (@(posedge clk)
        !rst_n |=> tap_pos == $past(recall_val));

    // R2 / R9: a load replaces the count even with a step present
    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> tap_pos == $past(load_val));

    // R3: exactly one tap enabled
    assert_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tap_sel) == 1);

    // R3: enable follows the count one cycle later
    assert_sel_track_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> tap_sel == (SEL_ONE << $past(tap_pos)));

    // R6: no wrap at the high end
    assert_sat_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && step_mode && step_pulse && step_up && tap_pos == POS_MAX)
        |=> tap_pos == POS_MAX);

    // R7: no wrap at the low end
    assert_sat_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && step_mode && step_pulse && !step_up && tap_pos == '0)
        |=> tap_pos == '0);

    // R8: no movement without a pulse in stepping mode
    assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !(step_mode && step_pulse)) |=> $stable(tap_pos));
endmodule

// File: tb/wiper_pos_counter_tb.sv
module wiper_pos_counter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  recall_val = 6'd21;
    logic        load_en = 1'b0;
    logic [5:0]  load_val = '0;
    logic        step_mode = 1'b0;
    logic        step_pulse = 1'b0;
    logic        step_up = 1'b0;
    logic [5:0]  tap_pos;
    logic [63:0] tap_sel;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    wiper_pos_counter dut_i (
        .clk(clk), .rst_n(rst_n), .recall_val(recall_val),
        .load_en(load_en), .load_val(load_val),
        .step_mode(step_mode), .step_pulse(step_pulse), .step_up(step_up),
        .tap_pos(tap_pos), .tap_sel(tap_sel)
    );

    task automatic chk_pos(input logic [5:0] exp, input string req);
        checks++;
        if (tap_pos !== exp) begin
            errors++;
            $display("FAIL %s: tap_pos actual=%0d expected=%0d", req, tap_pos, exp);
        end
    endtask

    task automatic chk_sel(input logic [5:0] exp, input string req);
        checks++;
        if (tap_sel !== (64'd1 << exp)) begin
            errors++;
            $display("FAIL %s: tap_sel actual=%h expected=%h", req, tap_sel, 64'd1 << exp);
        end
    endtask

    // Load a value; pos due at next negedge, sel one cycle later
    task automatic do_load(input logic [5:0] v, input string req);
        @(negedge clk); load_en = 1'b1; load_val = v;
        @(negedge clk); load_en = 1'b0;
        chk_pos(v, req);
        @(negedge clk);
        chk_sel(v, req);
    endtask

    // One step pulse, then check the count
    task automatic do_step(input logic up, input logic [5:0] exp, input string req);
        @(negedge clk); step_mode = 1'b1; step_pulse = 1'b1; step_up = up;
        @(negedge clk); step_pulse = 1'b0;
        chk_pos(exp, req);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_pos(6'd21, "R1");
        chk_sel(6'd21, "R1");
    endtask

    task automatic t_load();
        do_load(6'd40, "R2");
        do_load(6'd7, "R2");
    endtask

    task automatic t_step();
        do_load(6'd40, "R4");
        for (int i = 1; i <= 3; i++) do_step(1'b1, 6'(40 + i), "R4");
        @(negedge clk); chk_sel(6'd43, "R3");
        for (int i = 1; i <= 5; i++) do_step(1'b0, 6'(43 - i), "R5");
        @(negedge clk); chk_sel(6'd38, "R3");
        step_mode = 1'b0;
    endtask

    task automatic t_sat_hi();
        do_load(6'd62, "R6");
        do_step(1'b1, 6'd63, "R6");
        do_step(1'b1, 6'd63, "R6");
        do_step(1'b1, 6'd63, "R6");
        @(negedge clk); chk_sel(6'd63, "R3");
        step_mode = 1'b0;
    endtask

    task automatic t_sat_lo();
        do_load(6'd1, "R7");
        do_step(1'b0, 6'd0, "R7");
        do_step(1'b0, 6'd0, "R7");
        @(negedge clk); chk_sel(6'd0, "R3");
        step_mode = 1'b0;
    endtask

    task automatic t_ignore();
        do_load(6'd30, "R8");
        // Pulses with mode closed
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); step_mode = 1'b0; step_pulse = 1'b1; step_up = i[0];
        end
        @(negedge clk); step_pulse = 1'b0;
        chk_pos(6'd30, "R8");
        // Mode open, direction toggling, no pulse
        step_mode = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); step_up = ~step_up;
        end
        @(negedge clk);
        chk_pos(6'd30, "R8");
        chk_sel(6'd30, "R8");
        step_mode = 1'b0;
    endtask

    task automatic t_priority();
        do_load(6'd50, "R9");
        @(negedge clk);
        step_mode = 1'b1; step_pulse = 1'b1; step_up = 1'b1;
        load_en = 1'b1; load_val = 6'd10;
        @(negedge clk);
        step_pulse = 1'b0; load_en = 1'b0; step_mode = 1'b0;
        chk_pos(6'd10, "R9");
        @(negedge clk);
        chk_sel(6'd10, "R9");
    endtask

    initial begin
        t_reset();
        t_load();
        t_step();
        t_sat_hi();
        t_sat_lo();
        t_ignore();
        t_priority();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog: run actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule